// File: doc/BRIEF.md
# Encoded Priority Interrupt Input Filter

This block receives an interrupt priority from outside the chip as a four-bit code on four pins, held as a steady level rather than as a pulse. The code is active-low in meaning. A code of all zeros asks for the most urgent level, 15. A code of all ones means nothing is pending, which is level 0. The pins first pass through a two-flop synchroniser. A noise filter then accepts a new code only when two consecutive samples agree. The filtered code is turned into a priority of 0 to 15 and compared against the CPU's four-bit interrupt mask. A request is raised only when the priority is strictly above the mask.

A sample-enable input qualifies every sampling step. The filter can therefore run from a divided or slow-clock strobe, as it does in a low-power state where the fast clock is stopped. If that strobe never arrives, the filtered level never moves, so the block cannot raise a request to wake the system.

When the CPU takes the interrupt, an accept strobe copies the current filtered level into a service register. A service-done strobe clears that register. The external source must keep its level until acceptance, but it may raise the level before then, and the filter follows the higher level.

Top module: `prio_pin_filter`

## Requirements
- R1: `level_o` equals 15 minus the filtered pin code, which is the bitwise inverse of the four-bit code.
- R2: Pin code 0000 gives `level_o` = 15. Pin code 1111 gives `level_o` = 0, and `req_o` is then always 0.
- R3: `req_o` is 1 exactly when `level_o` is strictly greater than `mask`. An equal mask gives no request, and a mask of 15 never gives a request.
- R4: The filtered code changes only when two consecutive enabled samples are identical. A pin value present for a single sample has no effect on `level_o`. A later, higher level that is held steady is followed.
- R5: While `sample_en` is 0, no sample is taken and `level_o` does not change, whatever the pins do.
- R6: During and directly after reset, `level_o`, `req_o` and `held_o` are all 0, because the filtered code resets to 1111.
- R7: A high `accept` at a rising edge loads `held_o` with the value `level_o` had before that edge. A high `service_done` without `accept` clears `held_o` to 0. If both are high on the same edge, the capture wins.
- R8: With `sample_en` held at 1, a steady new pin code reaches `level_o` on the fourth rising edge after it is applied: two synchroniser edges and two sample edges. Once the pins are already synchronised, re-enabling sampling updates `level_o` on the second enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Qualifies a sampling step of the stability filter |
| pins | input | 4 | Encoded priority from the external pins (0000 = level 15, 1111 = none) |
| mask | input | 4 | CPU interrupt mask level |
| accept | input | 1 | CPU takes the interrupt; capture the current level |
| service_done | input | 1 | End of service; clear the held level |
| level_o | output | 4 | Filtered priority, 0 to 15 |
| req_o | output | 1 | Interrupt request, priority above mask |
| held_o | output | 4 | Level captured at acceptance, 0 when idle |

## Verification
Two pairs of functions can act on the same clock edge, and each pair is tested.

The first pair is the capture of a level on acceptance and a change of the filtered level. The bench disables sampling while a new code settles in the synchroniser. It then re-enables sampling and raises `accept` on exactly the edge where the filter takes the second matching sample. The test passes only if `held_o` shows the old level while `level_o` shows the new one.

The second pair is `accept` and `service_done` on the same edge. The test passes only if `held_o` shows the captured level rather than 0.

// File: rtl/prio_pin_pkg.sv
package prio_pin_pkg;
    parameter int unsigned PRIO_W = 4;
    parameter int unsigned SYNC_STAGES = 2;

    typedef logic [PRIO_W-1:0] prio_t;

    // code that means "nothing pending"
    localparam prio_t IDLE_CODE = '1;
endpackage

// File: rtl/prio_sync.sv
module prio_sync
    import prio_pin_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic  clk,
    input  logic  rst_n,
    input  prio_t d_i,
    output prio_t q_o
);
    prio_t st_d [STAGES];
    prio_t st_q [STAGES];

    always_comb begin
        st_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) st_q[i] <= IDLE_CODE;
            else        st_q[i] <= st_d[i];
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/prio_stable_filter.sv
module prio_stable_filter
    import prio_pin_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample_en,
    input  prio_t sync_i,
    output prio_t code_o
);
    typedef struct packed {
        prio_t last;   // previous enabled sample
        prio_t code;   // accepted code
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sample_en) begin
            s_d.last = sync_i;
            if (sync_i == s_q.last) s_d.code = sync_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.last <= IDLE_CODE;
            s_q.code <= IDLE_CODE;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.code;
endmodule

// File: rtl/prio_level_cmp.sv
module prio_level_cmp
    import prio_pin_pkg::*;
(
    input  prio_t code_i,
    input  prio_t mask_i,
    output prio_t level_o,
    output logic  req_o
);
    prio_t lvl_d;

    always_comb begin
        lvl_d = ~code_i;          // (2^W - 1) - code
        req_o = lvl_d > mask_i;
    end

    assign level_o = lvl_d;
endmodule

// File: rtl/prio_pin_filter.sv
module prio_pin_filter
    import prio_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic [3:0] pins,
    input  logic [3:0] mask,
    input  logic       accept,
    input  logic       service_done,
    output logic [3:0] level_o,
    output logic       req_o,
    output logic [3:0] held_o
);
    typedef struct packed {
        prio_t held;
    } svc_t;

    prio_t sync_w, code_w, level_w;
    logic  req_w;
    svc_t  v_d, v_q;

    prio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins),
        .q_o   (sync_w)
    );

    prio_stable_filter u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .sync_i    (sync_w),
        .code_o    (code_w)
    );

    prio_level_cmp u_cmp (
        .code_i  (code_w),
        .mask_i  (mask),
        .level_o (level_w),
        .req_o   (req_w)
    );

    always_comb begin
        v_d = v_q;
        if (accept)            v_d.held = level_w;
        else if (service_done) v_d.held = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign level_o = level_w;
    assign req_o   = req_w;
    assign held_o  = v_q.held;
endmodule

module prio_pin_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_en,
    input logic [3:0] mask,
    input logic       accept,
    input logic       service_done,
    input logic [3:0] level_o,
    input logic       req_o,
    input logic [3:0] held_o
);
    // R2
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 4'd0) |-> !req_o);

    // R3
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 4'hF) |-> !req_o);

    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(level_o));

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (held_o == $past(level_o)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (service_done && !accept) |=> (held_o == 4'd0));
endmodule

bind prio_pin_filter prio_pin_filter_chk u_chk (.*);

// File: tb/prio_pin_filter_bench.sv
`timescale 1ns/1ps
module prio_pin_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b1;
    logic [3:0] pins = 4'hF;
    logic [3:0] mask = 4'h0;
    logic       accept = 1'b0;
    logic       service_done = 1'b0;
    logic [3:0] level_o;
    logic       req_o;
    logic [3:0] held_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    prio_pin_filter u_prio_pin_filter (.*);

    // {pins, mask, expected level, expected req}
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {4'h0, 4'h0, 4'hF, 1'b1},
        {4'hF, 4'h0, 4'h0, 1'b0},
        {4'hA, 4'h4, 4'h5, 1'b1},
        {4'hA, 4'h5, 4'h5, 1'b0},
        {4'hA, 4'h6, 4'h5, 1'b0},
        {4'h3, 4'hB, 4'hC, 1'b1},
        {4'h0, 4'hF, 4'hF, 1'b0},
        {4'h1, 4'hD, 4'hE, 1'b1},
        {4'h7, 4'h7, 4'h8, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    initial begin
        int bad;
        // R6 reset state
        step(3);
        check("R6 level in reset", level_o, 0);
        check("R6 req in reset", req_o, 0);
        check("R6 held in reset", held_o, 0);
        rst_n = 1'b1;
        step(1);
        check("R6 level after reset", level_o, 0);

        // R1 R2 R3 table
        for (int i = 0; i < NV; i++) begin
            pins = VEC[i][12:9];
            mask = VEC[i][8:5];
            step(6);
            check($sformatf("R1 level vec %0d", i), level_o, VEC[i][4:1]);
            check($sformatf("R3 req vec %0d", i), req_o, VEC[i][0]);
        end

        // R8 latency from idle
        mask = 4'h0;
        pins = 4'hF;
        step(6);
        pins = 4'h5;
        step(3);
        check("R8 before 4th edge", level_o, 0);
        step(1);
        check("R8 at 4th edge", level_o, 10);

        // R4 single-sample glitch rejected
        pins = 4'hF;
        step(6);
        pins = 4'h0;
        step(1);
        pins = 4'hF;
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            step(1);
            if (level_o != 4'd0) bad++;
        end
        check("R4 glitch ignored", bad, 0);

        // R4 higher level followed
        pins = 4'h9;
        step(6);
        pins = 4'h2;
        step(6);
        check("R4 higher level followed", level_o, 13);

        // R5 sampling disabled
        pins = 4'hF;
        step(6);
        sample_en = 1'b0;
        pins = 4'h0;
        step(10);
        check("R5 level frozen", level_o, 0);
        check("R5 req frozen", req_o, 0);
        sample_en = 1'b1;
        step(1);
        check("R8 first enabled edge", level_o, 0);
        step(1);
        check("R8 second enabled edge", level_o, 15);

        // R7 capture, hold, release
        accept = 1'b1;
        step(1);
        accept = 1'b0;
        check("R7 capture", held_o, 15);
        pins = 4'hC;
        step(6);
        check("R7 held unaffected by level", held_o, 15);
        check("R1 new level", level_o, 3);
        service_done = 1'b1;
        step(1);
        service_done = 1'b0;
        check("R7 release", held_o, 0);

        // R7 accept and service_done on the same edge
        accept = 1'b1;
        service_done = 1'b1;
        step(1);
        accept = 1'b0;
        service_done = 1'b0;
        check("R7 capture beats release", held_o, 3);

        // R7 capture on the edge where the filter updates
        service_done = 1'b1;
        step(1);
        service_done = 1'b0;
        sample_en = 1'b0;
        pins = 4'h6;
        step(6);
        sample_en = 1'b1;
        step(1);
        accept = 1'b1;
        step(1);
        accept = 1'b0;
        check("R7 held gets old level", held_o, 3);
        check("R4 level updated same edge", level_o, 9);

        finish_run();
    end
endmodule